// File: doc/BRIEF.md
# ADC Output Code Formatter

This block sits between a 12-bit pipelined converter and the parallel data pins of an imaging front end. Each clock it takes one raw conversion code and produces the word that leaves the chip. On the way it can replace the code with a programmable black clamp level during pre-blanking, and it can re-express the stream in one of four formats: plain binary, Gray, differential binary or differential Gray. It can invert the top bit, the lower bits or both for test. It also gates the pins for output enable and standby.

In the differential formats each output word is the present code minus the code two samples earlier, wrapped modulo 2^12. Downstream logic rebuilds the absolute values from two periodic reference words. These are absolute samples that the block inserts on a selectable pair of clocks after each optical-black pulse. The pulse can be captured on either clock edge. The pre-blanking input is delayed to line up with the converter's 12-clock latency, so the clamp level lands on exactly the samples that were taken while blanking was active.

Top module: `adc_out_formatter`

## Requirements
- R1: While reset is held and on the first clock after it, `data_out` is 0 and `data_en` is 0.
- R2: A code presented with `code_valid` high appears on `data_out` one clock later. With `code_valid` low and standby low, `data_out` holds its value.
- R3: When `preblank` is high in cycle c, the sample presented in cycle c+12 is replaced by the clamp level 2*`clamp_sel`+14. With `clamp_sel`=9 this gives 32.
- R4: `inv_msb` inverts bit 11 only. `inv_lsbs` inverts bits 10..0. Both together invert all 12 bits. Inversion is the last operation applied.
- R5: With `fmt_sel`=01 the output is the Gray code of the (possibly substituted) sample, computed as v XOR (v>>1).
- R6: With `fmt_sel`=10 the output is (sample minus the valid sample two before) mod 4096. With `fmt_sel`=11 it is the Gray code of that difference.
- R7: If the optical-black pulse is first captured at clock edge E, the samples captured at edges E+3+s and E+4+s are sent absolute in the differential formats, where s is `ref_pair_sel` (0..3).
- R8: With `ob_fall_edge`=0 the pulse is sampled on the rising clock edge. With `ob_fall_edge`=1 it is sampled on the falling edge, so a pulse that rises in the second half of a clock cycle moves the reference pair one clock later.
- R9: With `out_en_n` high, `data_en` is low on the next clock. Formatting continues, and the data is visible again as soon as the pins are enabled.
- R10: In standby, `data_out` is 0 and `data_en` is 0 regardless of the other modes. The two-sample history is cleared, so the first two samples after leaving standby are differenced against 0.
- R11: The clamp level enters the differential history like any other sample. A blanked sample that falls in the reference pair is sent as the absolute clamp level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | 12 | Raw converter code |
| code_valid | input | 1 | code_in carries a sample this cycle |
| preblank | input | 1 | Pre-blanking request, active high, before latency alignment |
| ob_pulse | input | 1 | Optical-black pulse, active high |
| out_en_n | input | 1 | Output disable when high |
| standby | input | 1 | Low-power wait state |
| fmt_sel | input | 2 | 00 binary, 01 Gray, 10 differential, 11 differential Gray |
| inv_msb | input | 1 | Invert bit 11 |
| inv_lsbs | input | 1 | Invert bits 10..0 |
| ref_pair_sel | input | 2 | Reference pair offset s |
| ob_fall_edge | input | 1 | Sample ob_pulse on the falling edge |
| clamp_sel | input | 5 | Clamp setting; level is 2*value+14 |
| data_out | output | 12 | Formatted word |
| data_en | output | 1 | Pin drive enable (stands in for high impedance) |

## Verification
The collision that matters is a blanked sample landing on one of the two reference clocks while a differential format is active. In that cycle the substitution and the reference insertion both act on the same word. The bench provokes it by raising `preblank` exactly 12 clocks before the third sample after an optical-black pulse. It expects the plain clamp level, Gray-coded and inverted as configured. It also expects the following differential words to be taken against that clamp level. A second overlap, standby arriving while blanked differential data flows, is judged by the zeroed output and by differencing against zero after exit.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;

    typedef enum logic [1:0] {
        FMT_BIN   = 2'b00,
        FMT_GRAY  = 2'b01,
        FMT_DIFF  = 2'b10,
        FMT_DGRAY = 2'b11
    } fmt_e;

    typedef struct packed {
        fmt_e fmt;
        logic inv_msb;
        logic inv_lsbs;
    } omode_t;

    localparam int unsigned CLAMP_MUL = 2;
    localparam int unsigned CLAMP_OFS = 14;
    localparam int unsigned REF_FIRST = 3;

    function automatic logic fmt_is_diff(fmt_e f);
        return f[1];
    endfunction

    function automatic logic fmt_is_gray(fmt_e f);
        return f[0];
    endfunction

endpackage

// File: rtl/adcfmt_blank_dly.sv
module adcfmt_blank_dly #(
    parameter int unsigned LAT = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic blank_i,
    output logic blank_al
);

    logic [LAT-1:0] sr;

    generate
        if (LAT == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= blank_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[LAT-2:0], blank_i};
            end
        end
    endgenerate

    assign blank_al = sr[LAT-1];

endmodule

// File: rtl/adcfmt_obwin.sv
module adcfmt_obwin
    import adcfmt_pkg::*;
#(
    parameter int unsigned CNT_W = 3,
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ob_pulse,
    input  logic             fall_sel,
    input  logic [SEL_W-1:0] pair_sel,
    output logic             ref_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             ob_neg;
    logic             ob_q;
    logic             ob_prev;
    logic             rise;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] first;

    always_ff @(negedge clk) begin
        if (rst) ob_neg <= 1'b0;
        else     ob_neg <= ob_pulse;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ob_q    <= 1'b0;
            ob_prev <= 1'b0;
        end else begin
            ob_q    <= fall_sel ? ob_neg : ob_pulse;
            ob_prev <= ob_q;
        end
    end

    assign rise = ob_q & ~ob_prev;

    always_ff @(posedge clk) begin
        if (rst)                             cnt <= '0;
        else if (rise)                       cnt <= CNT_W'(1);
        else if (cnt != '0 && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
    end

    assign first = CNT_W'(REF_FIRST - 1) + CNT_W'(pair_sel);
    assign ref_o = (cnt == first) || (cnt == first + CNT_W'(1));

    AST_NO_REF_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !ref_o); // R7

    AST_REF_PAIR_ONLY: assert property (@(posedge clk) disable iff (rst)
        (ref_o && $past(ref_o) && $stable(pair_sel) && !rise) |=> !ref_o); // R7

endmodule

// File: rtl/adcfmt_codepath.sv
module adcfmt_codepath
    import adcfmt_pkg::*;
#(
    parameter int unsigned DATA_W  = 12,
    parameter int unsigned CLAMP_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  code,
    input  logic               vld,
    input  logic               blank_al,
    input  logic               ref_i,
    input  logic               stby,
    input  logic               oe_n,
    input  omode_t             mode,
    input  logic [CLAMP_W-1:0] clamp_sel,
    output logic [DATA_W-1:0]  dout,
    output logic               de
);

    logic [DATA_W-1:0] clamp_val;
    logic [DATA_W-1:0] sel_v;
    logic [DATA_W-1:0] hist1, hist2;
    logic [DATA_W-1:0] diff_v;
    logic [DATA_W-1:0] pre_v;
    logic [DATA_W-1:0] gray_v;
    logic [DATA_W-1:0] inv_mask;

    assign clamp_val = DATA_W'(CLAMP_MUL * int'(clamp_sel) + CLAMP_OFS);
    assign sel_v     = blank_al ? clamp_val : code;
    assign diff_v    = sel_v - hist2;
    assign pre_v     = (fmt_is_diff(mode.fmt) && !ref_i) ? diff_v : sel_v;
    assign gray_v    = fmt_is_gray(mode.fmt) ? (pre_v ^ (pre_v >> 1)) : pre_v;
    assign inv_mask  = {mode.inv_msb, {(DATA_W-1){mode.inv_lsbs}}};

    always_ff @(posedge clk) begin
        if (rst || stby) begin
            dout  <= '0;
            hist1 <= '0;
            hist2 <= '0;
        end else if (vld) begin
            dout  <= gray_v ^ inv_mask;
            hist1 <= sel_v;
            hist2 <= hist1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) de <= 1'b0;
        else     de <= ~stby & ~oe_n;
    end

    AST_STBY_FORCED: assert property (@(posedge clk) disable iff (rst)
        stby |=> (dout == '0 && !de)); // R10

    AST_STBY_HIST_CLR: assert property (@(posedge clk) disable iff (rst)
        stby |=> (hist1 == '0 && hist2 == '0)); // R10

    AST_OE_DISABLES: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> !de); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!vld && !stby) |=> $stable(dout)); // R2

    AST_BLANK_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (blank_al && vld && !stby && mode == '0)
            |=> dout == DATA_W'(CLAMP_MUL * int'($past(clamp_sel)) + CLAMP_OFS)); // R3

endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
    import adcfmt_pkg::*;
#(
    parameter int unsigned DATA_W    = 12,
    parameter int unsigned CLAMP_W   = 5,
    parameter int unsigned BLANK_LAT = 12,
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned CNT_W     = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  code_in,
    input  logic               code_valid,
    input  logic               preblank,
    input  logic               ob_pulse,
    input  logic               out_en_n,
    input  logic               standby,
    input  logic [1:0]         fmt_sel,
    input  logic               inv_msb,
    input  logic               inv_lsbs,
    input  logic [SEL_W-1:0]   ref_pair_sel,
    input  logic               ob_fall_edge,
    input  logic [CLAMP_W-1:0] clamp_sel,
    output logic [DATA_W-1:0]  data_out,
    output logic               data_en
);

    logic   blank_al;
    logic   ref_now;
    omode_t mode;

    assign mode.fmt      = fmt_e'(fmt_sel);
    assign mode.inv_msb  = inv_msb;
    assign mode.inv_lsbs = inv_lsbs;

    adcfmt_blank_dly #(.LAT(BLANK_LAT)) u_blank (
        .clk      (clk),
        .rst      (rst),
        .blank_i  (preblank),
        .blank_al (blank_al)
    );

    adcfmt_obwin #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_obwin (
        .clk      (clk),
        .rst      (rst),
        .ob_pulse (ob_pulse),
        .fall_sel (ob_fall_edge),
        .pair_sel (ref_pair_sel),
        .ref_o    (ref_now)
    );

    adcfmt_codepath #(.DATA_W(DATA_W), .CLAMP_W(CLAMP_W)) u_path (
        .clk       (clk),
        .rst       (rst),
        .code      (code_in),
        .vld       (code_valid),
        .blank_al  (blank_al),
        .ref_i     (ref_now),
        .stby      (standby),
        .oe_n      (out_en_n),
        .mode      (mode),
        .clamp_sel (clamp_sel),
        .dout      (data_out),
        .de        (data_en)
    );

endmodule

// File: tb/adc_out_formatter_tb.sv
module adc_out_formatter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] code_in = '0;
    logic        code_valid = 1'b0;
    logic        preblank = 1'b0;
    logic        ob_pulse = 1'b0;
    logic        out_en_n = 1'b0;
    logic        standby = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic        inv_msb = 1'b0;
    logic        inv_lsbs = 1'b0;
    logic [1:0]  ref_pair_sel = 2'b00;
    logic        ob_fall_edge = 1'b0;
    logic [4:0]  clamp_sel = 5'd9;
    logic [11:0] data_out;
    logic        data_en;

    // Requested configuration, applied at the start of the next step
    logic [1:0]  c_fmt = 2'b00;
    logic        c_imsb = 1'b0, c_ilsb = 1'b0, c_blank = 1'b0, c_obp = 1'b0;
    logic        c_oen = 1'b0, c_stby = 1'b0, c_fall = 1'b0;
    logic [1:0]  c_pair = 2'b00;
    logic [4:0]  c_clamp = 5'd9;

    int checks = 0;
    int errors = 0;
    int sc = 0;
    int obp_c0 = -100;
    string cur_req = "R1";

    logic [11:0] m_h1 = '0, m_h2 = '0, m_d = '0;
    logic        m_de = 1'b1;
    logic [11:0] prev_d = '0;
    logic        prev_de = 1'b1;
    logic        bl_hist [12];

    always #4 clk = ~clk;

    adc_out_formatter dut_i (
        .clk(clk), .rst(rst), .code_in(code_in), .code_valid(code_valid),
        .preblank(preblank), .ob_pulse(ob_pulse), .out_en_n(out_en_n),
        .standby(standby), .fmt_sel(fmt_sel), .inv_msb(inv_msb),
        .inv_lsbs(inv_lsbs), .ref_pair_sel(ref_pair_sel),
        .ob_fall_edge(ob_fall_edge), .clamp_sel(clamp_sel),
        .data_out(data_out), .data_en(data_en)
    );

    function automatic logic [11:0] gray12(input logic [11:0] v);
        return v ^ (v >> 1);
    endfunction

    task automatic check(input logic [11:0] exp_d, input logic exp_de);
        checks++;
        if (data_out !== exp_d || data_en !== exp_de) begin
            errors++;
            $display("FAIL %s step %0d: data_out=%0d data_en=%0b expected data_out=%0d data_en=%0b",
                     cur_req, sc, data_out, data_en, exp_d, exp_de);
        end
    endtask

    // One clock: drive at posedge+1, check the previous step's result at negedge
    task automatic step(input logic [11:0] code, input logic vld, input logic mid_obp = 1'b0);
        logic        blk, refw;
        logic [11:0] sel, pre;
        int          k;
        @(posedge clk);
        #1;
        if (c_obp && !ob_pulse) obp_c0 = sc;
        code_in = code; code_valid = vld; preblank = c_blank; ob_pulse = c_obp;
        out_en_n = c_oen; standby = c_stby; fmt_sel = c_fmt; inv_msb = c_imsb;
        inv_lsbs = c_ilsb; ref_pair_sel = c_pair; ob_fall_edge = c_fall; clamp_sel = c_clamp;
        blk = bl_hist[11];
        for (int i = 11; i > 0; i--) bl_hist[i] = bl_hist[i-1];
        bl_hist[0] = c_blank;
        k = sc - obp_c0;
        refw = (k == 3 + int'(c_pair)) || (k == 4 + int'(c_pair));
        if (c_stby) begin
            m_d = '0; m_h1 = '0; m_h2 = '0;
        end else if (vld) begin
            sel = blk ? 12'(2 * int'(c_clamp) + 14) : code;
            pre = (c_fmt[1] && !refw) ? sel - m_h2 : sel;
            if (c_fmt[0]) pre = gray12(pre);
            m_d = pre ^ {c_imsb, {11{c_ilsb}}};
            m_h2 = m_h1; m_h1 = sel;
        end
        m_de = !c_stby && !c_oen;
        @(negedge clk);
        check(prev_d, prev_de);
        prev_d = m_d; prev_de = m_de;
        if (mid_obp) begin
            #1;
            ob_pulse = 1'b1; c_obp = 1'b1;
            obp_c0 = sc + (c_fall ? 1 : 0);
        end
        sc++;
    endtask

    task automatic flush(input int n);
        for (int i = 0; i < n; i++) step(12'd0, 1'b0);
    endtask

    task automatic t_reset;
        cur_req = "R1";
        @(negedge clk);
        check(12'd0, 1'b0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (data_out !== 12'd0) begin
            errors++;
            $display("FAIL R1 after reset: data_out=%0d expected 0", data_out);
        end
    endtask

    task automatic t_binary;
        cur_req = "R2";
        c_fmt = 2'b00;
        step(12'd0, 1); step(12'd4095, 1); step(12'd1234, 1);
        step(12'd77, 0); step(12'd88, 0); step(12'd2048, 1);
        flush(1);
    endtask

    task automatic t_invert;
        cur_req = "R4";
        c_imsb = 1; c_ilsb = 0; step(12'h5A5, 1); step(12'h800, 1);
        c_imsb = 0; c_ilsb = 1; step(12'h5A5, 1); step(12'h000, 1);
        c_imsb = 1; c_ilsb = 1; step(12'h5A5, 1); step(12'hFFF, 1);
        c_imsb = 0; c_ilsb = 0; flush(1);
    endtask

    task automatic t_gray;
        cur_req = "R5";
        c_fmt = 2'b01;
        step(12'd2047, 1); step(12'd2048, 1); step(12'd4095, 1); step(12'd6, 1);
        c_imsb = 1; step(12'd3, 1); c_imsb = 0;
        c_fmt = 2'b00; flush(1);
    endtask

    task automatic t_diff;
        cur_req = "R6";
        c_fmt = 2'b10;
        step(12'd100, 1); step(12'd50, 1); step(12'd20, 1); step(12'd4000, 1);
        step(12'd9, 0); step(12'd30, 1);
        c_fmt = 2'b11;
        step(12'd500, 1); step(12'd700, 1); step(12'd480, 1);
        flush(1);
    endtask

    task automatic t_refwin;
        cur_req = "R7";
        c_fmt = 2'b10;
        for (int s = 0; s < 4; s++) begin
            c_pair = 2'(s);
            c_obp = 1; step(12'd1000, 1);
            c_obp = 0;
            for (int i = 1; i < 10; i++) step(12'(1000 + 37 * i), 1);
        end
        c_pair = 0; flush(1);
    endtask

    task automatic t_edge_sel;
        cur_req = "R8";
        c_fmt = 2'b10; c_pair = 0;
        for (int f = 0; f < 2; f++) begin
            c_fall = f[0];
            step(12'd10, 1, 1'b1);
            for (int i = 1; i < 10; i++) step(12'(10 + 100 * i), 1);
            c_obp = 0;
            for (int i = 0; i < 3; i++) step(12'd5, 1);
        end
        c_fall = 0; flush(1);
    endtask

    task automatic t_blank;
        cur_req = "R3";
        c_fmt = 2'b00; c_clamp = 5'd9;
        c_blank = 1; step(12'd111, 1); step(12'd222, 1);
        c_blank = 0;
        for (int i = 0; i < 14; i++) step(12'(3000 + i), 1);
        c_clamp = 5'd31; c_blank = 1; step(12'd1, 1); c_blank = 0;
        for (int i = 0; i < 13; i++) step(12'd1500, 1);
        c_clamp = 5'd9;
    endtask

    task automatic t_oe;
        cur_req = "R9";
        c_fmt = 2'b00;
        c_oen = 1; step(12'd321, 1); step(12'd654, 1);
        c_oen = 0; step(12'd987, 1); step(12'd12, 1);
    endtask

    task automatic t_standby;
        cur_req = "R10";
        c_fmt = 2'b11; c_imsb = 1;
        step(12'd900, 1); step(12'd950, 1);
        c_stby = 1; step(12'd1000, 1); step(12'd1100, 0);
        c_stby = 0; c_fmt = 2'b10; c_imsb = 0;
        step(12'd300, 1); step(12'd500, 1); step(12'd700, 1);
        flush(1);
    endtask

    task automatic t_overlap;
        cur_req = "R11";
        c_fmt = 2'b11; c_pair = 0; c_ilsb = 1; c_clamp = 5'd20;
        // blank raised 12 steps before the third sample after the pulse
        for (int i = 0; i < 3; i++) step(12'd400, 1);
        c_blank = 1; step(12'd410, 1); c_blank = 0;
        for (int i = 0; i < 8; i++) step(12'd420, 1);
        c_obp = 1; step(12'd430, 1); c_obp = 0;
        for (int i = 1; i < 8; i++) step(12'(430 + 25 * i), 1);
        // blanked differential stream then standby
        c_ilsb = 0; c_fmt = 2'b10;
        c_blank = 1; step(12'd800, 1); c_blank = 0;
        for (int i = 0; i < 12; i++) step(12'd810, 1);
        c_stby = 1; step(12'd820, 1); c_stby = 0;
        step(12'd830, 1); step(12'd840, 1); step(12'd850, 1);
        c_clamp = 5'd9; flush(1);
    endtask

    initial begin
        for (int i = 0; i < 12; i++) bl_hist[i] = 1'b0;
        repeat (3) @(posedge clk);
        t_reset;
        t_binary;
        t_invert;
        t_gray;
        t_diff;
        t_refwin;
        t_edge_sel;
        t_blank;
        t_oe;
        t_standby;
        t_overlap;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired during %s", cur_req);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule